// File: doc/BRIEF.md
# Prefixed Instruction Byte Framer

The framer sits behind the fetch path of an 8-bit processor whose instructions are built from optional prefix bytes, one opcode byte and up to two operand bytes. It receives the instruction stream one byte per cycle in which `valid_i` is high. For every byte it accepts, it reports the role of that byte: opcode, prefix, displacement, 8-bit immediate, or the low or high half of a 16-bit word. It also raises an end-of-instruction strobe that carries the total length and the final opcode byte. The framer does not execute or fetch anything. It only splits the stream into instructions so that a decoder downstream can see whole instructions.

Four prefix bytes are recognised: bit-operation (0xCB), extended (0xED), and the two index prefixes (0xDD, 0xFD). An index prefix followed by 0xCB forms the doubly prefixed indexed bit-operation form. In that form the displacement comes before the opcode, so the opcode is the fourth byte. An undefined opcode is framed as the shortest legal form for its prefix. The results for a byte appear one cycle after the byte is accepted.

Top module: `instr_framer`

## Requirements
- R1: After reset, and in the cycle after `resync_i` is high, the framer expects the first byte of a new instruction. `vld_o` and `eoi_o` are 0 during reset. A byte presented in the same cycle as `resync_i` is discarded and produces no output.
- R2: A cycle with `valid_i` low does not advance the framing. In the following cycle `vld_o` is 0, and an instruction that was interrupted by such gaps is framed exactly as it would be without them.
- R3: Each accepted byte produces `vld_o` = 1 exactly one cycle later, together with its role on `role_o`. The role codes are: 0 opcode, 1 prefix, 2 displacement, 3 8-bit immediate, 4 word low byte, 5 word high byte.
- R4: An unprefixed opcode with no operand is one byte long. Its single byte has role 0, and it carries `eoi_o` = 1 with `len_o` = 1.
- R5: The unprefixed relative jumps 0x10, 0x18, 0x20, 0x28, 0x30 and 0x38 are followed by one displacement byte (role 2). The 8-bit immediate opcodes 0x06, 0x0E, 0x16, 0x1E, 0x26, 0x2E, 0x36, 0x3E, 0xC6, 0xCE, 0xD3, 0xD6, 0xDB, 0xDE, 0xE6, 0xEE, 0xF6 and 0xFE are followed by one immediate byte (role 3). All of these are two bytes long.
- R6: The unprefixed opcodes 0x01, 0x11, 0x21, 0x31, 0x22, 0x2A, 0x32, 0x3A, 0xC3, 0xCD, 0xC2..0xFA in steps of 8, and 0xC4..0xFC in steps of 8 carry a 16-bit word. The word is sent low byte first (role 4), then high byte (role 5), for a total of three bytes.
- R7: 0xCB followed by any byte forms a two-byte instruction: prefix, then opcode.
- R8: 0xED followed by any byte is two bytes long. The exception is a second byte of 0x43, 0x4B, 0x53, 0x5B, 0x63, 0x6B, 0x73 or 0x7B, which is followed by a 16-bit word (low byte, then high byte) for a total of four bytes.
- R9: After 0xDD or 0xFD, an opcode that addresses memory through the index register is followed by a displacement byte. These opcodes are 0x34, 0x35, 0x36, 0x46, 0x4E, 0x56, 0x5E, 0x66, 0x6E, 0x7E, 0x70..0x75, 0x77, and 0x86..0xBE in steps of 8. Such an instruction is three bytes long, except 0x36, which is followed by the displacement and then an immediate byte, for four bytes.
- R10: 0xDD or 0xFD followed by 0xCB is framed as prefix, prefix, displacement, opcode. It is four bytes long, and the fourth byte is reported as the opcode.
- R11: After 0xDD or 0xFD, any other opcode takes the same operands as its unprefixed form, plus one byte for the prefix (for example 0xDD 0x21 is four bytes). A second byte of 0xDD, 0xED or 0xFD is framed as a two-byte instruction with that byte as its opcode.
- R12: With `eoi_o` = 1, `opc_o` is the final opcode byte of the instruction: the byte after the last prefix, or the fourth byte in the R10 form.
- R13: Instructions may follow each other with no gap. `len_o` is the number of bytes accepted since the previous end-of-instruction, and it is always between 1 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| resync_i | input | 1 | Abandon the current instruction and expect a first byte |
| valid_i | input | 1 | `byte_i` holds a stream byte this cycle |
| byte_i | input | 8 | Instruction stream byte |
| vld_o | output | 1 | The role outputs describe a byte accepted in the previous cycle |
| role_o | output | 3 | Role code of that byte |
| eoi_o | output | 1 | That byte ends an instruction |
| len_o | output | 3 | Total instruction length in bytes, valid with `eoi_o` |
| opc_o | output | 8 | Final opcode byte, valid with `eoi_o` |

## Verification
The bench sweeps every second-byte value behind each of the four prefixes, every unprefixed first byte, and every fourth byte of the indexed bit-operation form. This separates the operand classes byte by byte: none, displacement, immediate, word, and displacement plus immediate. The bench's expectations come from explicit opcode lists, not from field arithmetic, so a misplaced field boundary in the decoder shows up as a wrong length on a specific code. The instructions are streamed back to back, so a wrong length also shifts the roles of the instruction that follows. Separate sequences insert idle cycles inside a word operand and resynchronise in the middle of an instruction. These show that gaps are transparent and that a resync drops only the partial instruction.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;

  localparam logic [BYTE_W-1:0] PFX_BIT = 8'hCB;
  localparam logic [BYTE_W-1:0] PFX_EXT = 8'hED;
  localparam logic [BYTE_W-1:0] PFX_IX  = 8'hDD;
  localparam logic [BYTE_W-1:0] PFX_IY  = 8'hFD;

  typedef enum logic [2:0] {
    ROLE_OPC  = 3'd0,
    ROLE_PFX  = 3'd1,
    ROLE_DISP = 3'd2,
    ROLE_IMM  = 3'd3,
    ROLE_LO   = 3'd4,
    ROLE_HI   = 3'd5
  } role_e;

  typedef enum logic [1:0] {TBL_MAIN, TBL_EXT, TBL_IDX} tbl_e;

  typedef enum logic [3:0] {
    ST_FIRST, ST_BIT_OP, ST_EXT_OP, ST_IDX_OP, ST_XB_DISP,
    ST_XB_OP, ST_DISP, ST_IMM, ST_LO, ST_HI
  } st_e;

  typedef struct packed {
    logic pfx;
    logic disp;
    logic imm;
    logic word;
  } ocls_t;

  typedef struct packed {
    logic              vld;
    role_e             role;
    logic              eoi;
    logic [LEN_W-1:0]  len;
    logic [BYTE_W-1:0] opc;
  } beat_t;

  // displacement always precedes an immediate or word operand
  function automatic st_e after_opcode(ocls_t c);
    if (c.disp)      return ST_DISP;
    else if (c.imm)  return ST_IMM;
    else if (c.word) return ST_LO;
    else             return ST_FIRST;
  endfunction
endpackage

// File: rtl/frm_op_class.sv
module frm_op_class
  import frm_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  input  tbl_e              tbl_i,
  output ocls_t             cls_o
);
  logic [1:0] x;
  logic [2:0] y, z;
  logic       is_pfx, nests, mem, m_disp, m_imm, m_word;

  assign x = op_i[7:6];
  assign y = op_i[5:3];
  assign z = op_i[2:0];

  assign is_pfx = (op_i == PFX_BIT) || (op_i == PFX_EXT) ||
                  (op_i == PFX_IX)  || (op_i == PFX_IY);
  assign nests  = (op_i == PFX_EXT) || (op_i == PFX_IX) || (op_i == PFX_IY);

  assign m_disp = (x == 2'd0) && (z == 3'd0) && (y >= 3'd2);
  assign m_imm  = ((x == 2'd0) && (z == 3'd6)) ||
                  ((x == 2'd3) && (z == 3'd6)) ||
                  ((x == 2'd3) && (z == 3'd3) && ((y == 3'd2) || (y == 3'd3)));
  assign m_word = ((x == 2'd0) && (z == 3'd1) && !y[0]) ||
                  ((x == 2'd0) && (z == 3'd2) && y[2]) ||
                  ((x == 2'd3) && (z == 3'd2)) ||
                  ((x == 2'd3) && (z == 3'd4)) ||
                  ((x == 2'd3) && (z == 3'd3) && (y == 3'd0)) ||
                  ((x == 2'd3) && (z == 3'd5) && (y == 3'd1));
  // operand through the index register replaces the HL memory operand
  assign mem    = ((x == 2'd1) && ((z == 3'd6) || (y == 3'd6)) && !((z == 3'd6) && (y == 3'd6))) ||
                  ((x == 2'd2) && (z == 3'd6)) ||
                  ((x == 2'd0) && (y == 3'd6) && ((z == 3'd4) || (z == 3'd5) || (z == 3'd6)));

  always_comb begin
    cls_o = '0;
    case (tbl_i)
      TBL_MAIN: begin
        cls_o.pfx  = is_pfx;
        cls_o.disp = m_disp && !is_pfx;
        cls_o.imm  = m_imm;
        cls_o.word = m_word;
      end
      TBL_EXT: cls_o.word = (x == 2'd1) && (z == 3'd3);
      TBL_IDX: begin
        cls_o.pfx = (op_i == PFX_BIT);
        if (!nests && (op_i != PFX_BIT)) begin
          cls_o.disp = m_disp || mem;
          cls_o.imm  = m_imm;
          cls_o.word = m_word;
        end
      end
      default: cls_o = '0;
    endcase
  end
endmodule

// File: rtl/frm_seq.sv
module frm_seq
  import frm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              resync_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output beat_t             beat_o
);
  st_e               st_q, st_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d, len_d;
  logic [BYTE_W-1:0] op_q, op_d;
  logic              pimm_q, pimm_d, pword_q, pword_d;
  logic              acc, eoi;
  role_e             role;
  tbl_e              tbl;
  ocls_t             cls;

  assign tbl = (st_q == ST_EXT_OP) ? TBL_EXT :
               (st_q == ST_IDX_OP) ? TBL_IDX : TBL_MAIN;

  frm_op_class u_cls (
    .op_i  (byte_i),
    .tbl_i (tbl),
    .cls_o (cls)
  );

  assign acc = valid_i && !resync_i;

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    pimm_d  = pimm_q;
    pword_d = pword_q;
    role    = ROLE_OPC;
    case (st_q)
      ST_FIRST, ST_EXT_OP, ST_IDX_OP: begin
        if (cls.pfx) begin
          role = ROLE_PFX;
          if (st_q == ST_IDX_OP)         st_d = ST_XB_DISP;
          else if (byte_i == PFX_BIT)    st_d = ST_BIT_OP;
          else if (byte_i == PFX_EXT)    st_d = ST_EXT_OP;
          else                           st_d = ST_IDX_OP;
        end else begin
          op_d    = byte_i;
          pimm_d  = cls.imm;
          pword_d = cls.word;
          st_d    = after_opcode(cls);
        end
      end
      ST_BIT_OP, ST_XB_OP: begin
        op_d = byte_i;
        st_d = ST_FIRST;
      end
      ST_XB_DISP: begin
        role = ROLE_DISP;
        st_d = ST_XB_OP;
      end
      ST_DISP: begin
        role = ROLE_DISP;
        st_d = pimm_q ? ST_IMM : (pword_q ? ST_LO : ST_FIRST);
      end
      ST_IMM: begin
        role = ROLE_IMM;
        st_d = ST_FIRST;
      end
      ST_LO: begin
        role = ROLE_LO;
        st_d = ST_HI;
      end
      ST_HI: begin
        role = ROLE_HI;
        st_d = ST_FIRST;
      end
      default: st_d = ST_FIRST;
    endcase
    // prefixes never lead back to ST_FIRST
    eoi   = (st_d == ST_FIRST);
    len_d = cnt_q + LEN_W'(1);
    cnt_d = eoi ? '0 : len_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_FIRST;
      cnt_q   <= '0;
      op_q    <= '0;
      pimm_q  <= 1'b0;
      pword_q <= 1'b0;
    end else if (resync_i) begin
      st_q    <= ST_FIRST;
      cnt_q   <= '0;
      pimm_q  <= 1'b0;
      pword_q <= 1'b0;
    end else if (valid_i) begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      pimm_q  <= pimm_d;
      pword_q <= pword_d;
    end
  end

  always_comb begin
    beat_o.vld  = acc;
    beat_o.role = role;
    beat_o.eoi  = acc && eoi;
    beat_o.len  = len_d;
    beat_o.opc  = op_d;
  end

  // checker state: role of the last accepted byte
  role_e last_role_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_role_q <= ROLE_OPC;
    else if (acc) last_role_q <= role;
  end

  p_resync_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (st_q == ST_FIRST) && (cnt_q == '0));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !resync_i) |=> $stable(st_q) && $stable(cnt_q) && $stable(op_q));

  p_hi_after_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && role == ROLE_HI) |-> (last_role_q == ROLE_LO));

  p_bit_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && st_q == ST_BIT_OP) |-> (beat_o.eoi && beat_o.len == LEN_W'(2)));

  p_xbit_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && st_q == ST_XB_OP) |-> (beat_o.eoi && beat_o.len == LEN_W'(4) && beat_o.opc == byte_i));

  p_len_bounds_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o.eoi |-> (beat_o.len >= LEN_W'(1)) && (beat_o.len <= LEN_W'(4)));
endmodule

// File: rtl/frm_out_stage.sv
module frm_out_stage
  import frm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  beat_t beat_i,
  output beat_t beat_o
);
  generate
    if (OUT_REG) begin : g_reg
      beat_t q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= beat_i;
      end
      assign beat_o = q;
    end else begin : g_thru
      assign beat_o = beat_i;
    end
  endgenerate
endmodule

// File: rtl/instr_framer.sv
module instr_framer
  import frm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              resync_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              vld_o,
  output logic [2:0]        role_o,
  output logic              eoi_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [BYTE_W-1:0] opc_o
);
  beat_t raw, outb;

  frm_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .resync_i (resync_i),
    .valid_i  (valid_i),
    .byte_i   (byte_i),
    .beat_o   (raw)
  );

  frm_out_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (raw),
    .beat_o (outb)
  );

  assign vld_o  = outb.vld;
  assign role_o = outb.role;
  assign eoi_o  = outb.eoi;
  assign len_o  = outb.len;
  assign opc_o  = outb.opc;

  generate
    if (OUT_REG) begin : g_chk
      p_accept_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !resync_i) |=> vld_o);
      p_gap_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_i && !resync_i) |=> !vld_o && !eoi_o);
    end
  endgenerate
endmodule

// File: tb/sim_instr_framer.sv
module sim_instr_framer;
  localparam logic [2:0] R_OPC = 3'd0, R_PFX = 3'd1, R_DISP = 3'd2,
                         R_IMM = 3'd3, R_LO = 3'd4, R_HI = 3'd5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       resync_i = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       vld_o, eoi_o;
  logic [2:0] role_o, len_o;
  logic [7:0] opc_o;

  always #5 clk = ~clk;

  instr_framer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .resync_i(resync_i), .valid_i(valid_i),
    .byte_i(byte_i), .vld_o(vld_o), .role_o(role_o), .eoi_o(eoi_o),
    .len_o(len_o), .opc_o(opc_o)
  );

  int    checks = 0;
  int    fails  = 0;
  logic  ex_pend = 1'b0;
  logic [2:0] ex_role = '0, ex_len = '0;
  logic  ex_eoi = 1'b0;
  logic [7:0] ex_opc = '0;
  string ex_req = "R1";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_prev();
    if (ex_pend) begin
      chk(vld_o == 1'b1, ex_req, "vld", int'(vld_o), 1);
      chk(role_o == ex_role, ex_req, "role", int'(role_o), int'(ex_role));
      chk(eoi_o == ex_eoi, ex_req, "eoi", int'(eoi_o), int'(ex_eoi));
      if (ex_eoi) begin
        chk(len_o == ex_len, ex_req, "len", int'(len_o), int'(ex_len));
        chk(opc_o == ex_opc, "R12", "opc", int'(opc_o), int'(ex_opc));
      end
    end else begin
      chk(vld_o == 1'b0 && eoi_o == 1'b0, ex_req, "quiet", int'({vld_o, eoi_o}), 0);
    end
  endtask

  task automatic feed(logic [7:0] b, logic [2:0] role, bit eoi, logic [2:0] len,
                      logic [7:0] opc, string req);
    @(negedge clk);
    check_prev();
    valid_i  = 1'b1;
    resync_i = 1'b0;
    byte_i   = b;
    ex_pend  = 1'b1;
    ex_role  = role;
    ex_eoi   = eoi;
    ex_len   = len;
    ex_opc   = opc;
    ex_req   = req;
  endtask

  task automatic idle(string req);
    @(negedge clk);
    check_prev();
    valid_i  = 1'b0;
    resync_i = 1'b0;
    byte_i   = 8'hA5;
    ex_pend  = 1'b0;
    ex_req   = req;
  endtask

  // 0 none, 1 displacement, 2 immediate, 3 word
  function automatic int main_cls(logic [7:0] b);
    case (b)
      8'h10, 8'h18, 8'h20, 8'h28, 8'h30, 8'h38: return 1;
      8'h06, 8'h0E, 8'h16, 8'h1E, 8'h26, 8'h2E, 8'h36, 8'h3E, 8'hC6, 8'hCE,
      8'hD3, 8'hD6, 8'hDB, 8'hDE, 8'hE6, 8'hEE, 8'hF6, 8'hFE: return 2;
      8'h01, 8'h11, 8'h21, 8'h31, 8'h22, 8'h2A, 8'h32, 8'h3A, 8'hC3, 8'hCD,
      8'hC2, 8'hCA, 8'hD2, 8'hDA, 8'hE2, 8'hEA, 8'hF2, 8'hFA,
      8'hC4, 8'hCC, 8'hD4, 8'hDC, 8'hE4, 8'hEC, 8'hF4, 8'hFC: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic bit idx_mem(logic [7:0] b);
    case (b)
      8'h34, 8'h35, 8'h36, 8'h46, 8'h4E, 8'h56, 8'h5E, 8'h66, 8'h6E, 8'h7E,
      8'h70, 8'h71, 8'h72, 8'h73, 8'h74, 8'h75, 8'h77,
      8'h86, 8'h8E, 8'h96, 8'h9E, 8'hA6, 8'hAE, 8'hB6, 8'hBE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit ext_word(logic [7:0] b);
    case (b)
      8'h43, 8'h4B, 8'h53, 8'h5B, 8'h63, 8'h6B, 8'h73, 8'h7B: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit is_pfx(logic [7:0] b);
    return (b == 8'hCB) || (b == 8'hED) || (b == 8'hDD) || (b == 8'hFD);
  endfunction

  task automatic run_main(logic [7:0] b);
    int c = main_cls(b);
    string req = (c == 0) ? "R4" : (c == 3) ? "R6" : "R5";
    feed(b, R_OPC, c == 0, 3'd1, b, req);
    if (c == 1) feed(b ^ 8'h5C, R_DISP, 1'b1, 3'd2, b, req);
    if (c == 2) feed(~b, R_IMM, 1'b1, 3'd2, b, req);
    if (c == 3) begin
      feed(b ^ 8'h0F, R_LO, 1'b0, 3'd0, 8'h00, req);
      feed(b ^ 8'hF0, R_HI, 1'b1, 3'd3, b, req);
    end
  endtask

  task automatic run_ix(logic [7:0] p, logic [7:0] b);
    feed(p, R_PFX, 1'b0, 3'd0, 8'h00, "R11");
    if (is_pfx(b)) begin
      feed(b, R_OPC, 1'b1, 3'd2, b, "R11");
    end else begin
      bit m = idx_mem(b);
      int c = main_cls(b);
      string req = m ? "R9" : "R11";
      logic [2:0] n = m ? 3'd3 : 3'd2;
      feed(b, R_OPC, !m && c == 0, 3'd2, b, req);
      if (m) feed(8'h80 ^ b, R_DISP, c == 0, 3'd3, b, req);
      if (c == 1) feed(8'h7F, R_DISP, 1'b1, n + 3'd1, b, req);
      if (c == 2) feed(8'h42, R_IMM, 1'b1, n + 3'd1, b, req);
      if (c == 3) begin
        feed(8'h34, R_LO, 1'b0, 3'd0, 8'h00, req);
        feed(8'h12, R_HI, 1'b1, n + 3'd2, b, req);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(vld_o == 1'b0 && eoi_o == 1'b0, "R1", "reset outputs", int'({vld_o, eoi_o}), 0);
    rst_ni = 1'b1;
    idle("R1");

    // R4 R5 R6 R13: every unprefixed first byte, streamed back to back
    for (int i = 0; i < 256; i++)
      if (!is_pfx(8'(i))) run_main(8'(i));

    // R7: bit-operation prefix with every second byte
    for (int i = 0; i < 256; i++) begin
      feed(8'hCB, R_PFX, 1'b0, 3'd0, 8'h00, "R7");
      feed(8'(i), R_OPC, 1'b1, 3'd2, 8'(i), "R7");
    end

    // R8: extended prefix with every second byte
    for (int i = 0; i < 256; i++) begin
      feed(8'hED, R_PFX, 1'b0, 3'd0, 8'h00, "R8");
      if (ext_word(8'(i))) begin
        feed(8'(i), R_OPC, 1'b0, 3'd0, 8'h00, "R8");
        feed(8'hEF, R_LO, 1'b0, 3'd0, 8'h00, "R8");
        feed(8'hBE, R_HI, 1'b1, 3'd4, 8'(i), "R8");
      end else begin
        feed(8'(i), R_OPC, 1'b1, 3'd2, 8'(i), "R8");
      end
    end

    // R9 R11: both index prefixes with every second byte except 0xCB
    for (int i = 0; i < 256; i++)
      if (i != 8'hCB) begin
        run_ix(8'hDD, 8'(i));
        run_ix(8'hFD, 8'(i));
      end

    // R10: indexed bit-operation form with every fourth byte
    for (int i = 0; i < 256; i++) begin
      logic [7:0] p = i[0] ? 8'hFD : 8'hDD;
      feed(p, R_PFX, 1'b0, 3'd0, 8'h00, "R10");
      feed(8'hCB, R_PFX, 1'b0, 3'd0, 8'h00, "R10");
      feed(8'(i) ^ 8'h96, R_DISP, 1'b0, 3'd0, 8'h00, "R10");
      feed(8'(i), R_OPC, 1'b1, 3'd4, 8'(i), "R10");
    end

    // R2: gaps inside a call and inside an indexed store
    feed(8'hCD, R_OPC, 1'b0, 3'd0, 8'h00, "R2");
    idle("R2");
    idle("R2");
    feed(8'h00, R_LO, 1'b0, 3'd0, 8'h00, "R2");
    idle("R2");
    feed(8'hC0, R_HI, 1'b1, 3'd3, 8'hCD, "R2");
    feed(8'hFD, R_PFX, 1'b0, 3'd0, 8'h00, "R2");
    idle("R2");
    feed(8'h36, R_OPC, 1'b0, 3'd0, 8'h00, "R2");
    feed(8'hFE, R_DISP, 1'b0, 3'd0, 8'h00, "R2");
    idle("R2");
    feed(8'h99, R_IMM, 1'b1, 3'd4, 8'h36, "R2");

    // R1: resync in the middle of a word operand
    feed(8'hC3, R_OPC, 1'b0, 3'd0, 8'h00, "R1");
    feed(8'h10, R_LO, 1'b0, 3'd0, 8'h00, "R1");
    @(negedge clk);
    check_prev();
    resync_i = 1'b1;
    valid_i  = 1'b1;
    byte_i   = 8'hCB;
    ex_pend  = 1'b0;
    ex_req   = "R1";
    feed(8'h00, R_OPC, 1'b1, 3'd1, 8'h00, "R1");
    // R1: resync right after an index prefix
    feed(8'hDD, R_PFX, 1'b0, 3'd0, 8'h00, "R1");
    @(negedge clk);
    check_prev();
    resync_i = 1'b1;
    valid_i  = 1'b0;
    ex_pend  = 1'b0;
    ex_req   = "R1";
    feed(8'h7E, R_OPC, 1'b1, 3'd1, 8'h7E, "R1");

    idle("R3");
    idle("R3");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL R13 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end
endmodule